// File: doc/BRIEF.md
# Self-Checking Constant-Weight Control Field Decoder

This block turns an 8-bit control field, legally holding exactly four ones, into one of 70 control strobes, and watches its own work while doing so. The field is cut into a low and a high nibble. Each nibble drives a 16-output pattern decoder built only from true input bits. A pattern output is active whenever every one-bit of its pattern is present in the nibble, so several outputs of one nibble can be active together. A control strobe is the AND of one low-nibble output and one high-nibble output whose pattern weights add up to four.

For the self-check, each nibble's outputs are masked by the outputs of the complementary weight group in the other nibble. On a legal field this leaves exactly one survivor per nibble. The survivors are re-encoded into the bitwise inverse of the field, and that word goes through a two-rail weight checker. The checker's rails disagree only for a weight-four word. When the rails agree while the field is qualified as valid, the error flag is registered one cycle later. An unqualified cycle, such as the all-zero word seen while the instruction register is being cleared, is idle and never flags.

Top module: `ctrl_field_decoder`

## Requirements
- R1: Control strobe ctrlPoint[k] is high in the same cycle, combinationally, exactly when fieldIn contains every one-bit of C_k. C_k is the k-th value, counting from 0, among the 8-bit values with exactly four ones, taken in ascending numeric order (C_0 = 8'h0F, C_69 = 8'hF0).
- R2: For p in 0..15, groupOut[p] is high exactly when (fieldIn[3:0] & p) == p. groupOut[16+p] is high exactly when (fieldIn[7:4] & p) == p.
- R3: A nibble of all ones drives all 16 of its group outputs high. A nibble of all zeros drives only its pattern-0 output high.
- R4: A field with fewer than four ones fires no control strobe. A field with exactly four ones fires exactly one.
- R5: When fieldValid is high at a rising edge and fieldIn does not hold exactly four ones, errFlag is high after that edge.
- R6: When fieldValid is high at a rising edge and fieldIn holds exactly four ones, errFlag is low after that edge. Internally, exactly one masked output per nibble survives, and the re-encoded word is the inverse of fieldIn.
- R7: When fieldValid is low at a rising edge, errFlag is low after that edge, whatever the field, the all-zero field included.
- R8: While rstN is low, errFlag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fieldIn | input | 8 | Registered control field |
| fieldValid | input | 1 | Field qualifier; low marks an idle cycle |
| ctrlPoint | output | 70 | Decoded control strobes, one per legal code |
| groupOut | output | 32 | Nibble pattern outputs, low nibble in [15:0], high nibble in [31:16] |
| errFlag | output | 1 | Registered code-check failure |

## Verification
The combinational strobes for one field and the registered verdict on the field before it are both visible in the same cycle. An over-weight field also lights several strobes at once while its flag follows an edge later. The bench therefore checks the strobes and group outputs a nanosecond after driving a field, then checks the flag just after the following edge, with the expected verdict computed from the driven field's weight and qualifier. Random sequences toggle fieldValid between consecutive illegal and legal fields. This shows that an idle cycle clears a pending flag and that a legal field right after an illegal one does not inherit its verdict.

// File: rtl/cfdec_pkg.sv
package cfdec_pkg;

  localparam int FIELD_W    = 8;
  localparam int HALF_W     = FIELD_W / 2;
  localparam int HALF_N     = 1 << HALF_W;
  localparam int WEIGHT     = FIELD_W / 2;
  localparam int GROUP_N    = 2 * HALF_N;
  localparam int NUM_POINTS = 70;

  typedef struct packed {
    logic checkEn;
    logic clearFlag;
  } ctrlStrobe_t;

  function automatic int popCount(input int value, input int width);
    int n;
    n = 0;
    for (int b = 0; b < width; b++) begin
      if (((value >> b) & 1) == 1) n++;
    end
    return n;
  endfunction

  function automatic int pointRank(input int value);
    int r;
    r = 0;
    for (int u = 0; u < value; u++) begin
      if (popCount(u, FIELD_W) == WEIGHT) r++;
    end
    return r;
  endfunction

  function automatic logic [HALF_N-1:0] weightMask(input int w);
    logic [HALF_N-1:0] m;
    m = '0;
    for (int p = 0; p < HALF_N; p++) begin
      if (popCount(p, HALF_W) == w) m[p] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [HALF_N-1:0] bitClearMask(input int bitIdx);
    logic [HALF_N-1:0] m;
    m = '0;
    for (int p = 0; p < HALF_N; p++) begin
      if (((p >> bitIdx) & 1) == 0) m[p] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/cfdec_half_decoder.sv
module cfdec_half_decoder #(
  parameter int HALF_W = 4,
  localparam int HALF_N = 1 << HALF_W
) (
  input  logic [HALF_W-1:0] halfIn,
  output logic [HALF_N-1:0] patHit
);

  // Pattern p is covered when every bit it sets is set in the input.
  // Only true inputs are used; no inverted copies of halfIn exist.
  for (genvar p = 0; p < HALF_N; p++) begin : g_pat
    localparam logic [HALF_W-1:0] PAT = HALF_W'(p);
    assign patHit[p] = &(halfIn | ~PAT);
  end

endmodule

// File: rtl/cfdec_checker.sv
module cfdec_checker
  import cfdec_pkg::*;
(
  input  logic [FIELD_W-1:0] codeIn,
  output logic [1:0]         rails
);

  logic [2:0] loOnes;
  logic [2:0] hiOnes;

  always_comb begin
    loOnes = '0;
    hiOnes = '0;
    for (int b = 0; b < HALF_W; b++) begin
      loOnes = loOnes + 3'(codeIn[b]);
      hiOnes = hiOnes + 3'(codeIn[HALF_W+b]);
    end
  end

  // Split the weight-four cases by parity of the low count: the two
  // rails differ only for a weight-four word, and both are low otherwise.
  always_comb begin
    rails = 2'b00;
    for (int k = 0; k <= WEIGHT; k++) begin
      if (loOnes == 3'(k) && hiOnes == 3'(WEIGHT - k)) begin
        rails[k % 2] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cfdec_ctrl.sv
module cfdec_ctrl
  import cfdec_pkg::*;
(
  input  logic        fieldValid,
  output ctrlStrobe_t strobes
);

  always_comb begin
    strobes.checkEn   = fieldValid;
    strobes.clearFlag = ~fieldValid;
  end

endmodule

// File: rtl/cfdec_datapath.sv
module cfdec_datapath
  import cfdec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [FIELD_W-1:0]    fieldIn,
  input  ctrlStrobe_t           strobes,
  output logic [NUM_POINTS-1:0] ctrlPoint,
  output logic [GROUP_N-1:0]    groupOut,
  output logic                  errFlag
);

  logic [HALF_N-1:0]  loHit;
  logic [HALF_N-1:0]  hiHit;
  logic [HALF_N-1:0]  loPass;
  logic [HALF_N-1:0]  hiPass;
  logic [FIELD_W-1:0] compWord;
  logic [1:0]         rails;

  cfdec_half_decoder #(.HALF_W(HALF_W)) loDec_i (
    .halfIn (fieldIn[HALF_W-1:0]),
    .patHit (loHit)
  );

  cfdec_half_decoder #(.HALF_W(HALF_W)) hiDec_i (
    .halfIn (fieldIn[FIELD_W-1:HALF_W]),
    .patHit (hiHit)
  );

  assign groupOut = {hiHit, loHit};

  // One control strobe per weight-four value, ranked in ascending order.
  for (genvar v = 0; v < (1 << FIELD_W); v++) begin : g_point
    if (popCount(v, FIELD_W) == WEIGHT) begin : g_legal
      localparam int RANK = pointRank(v);
      localparam int LO   = v % HALF_N;
      localparam int HI   = v / HALF_N;
      assign ctrlPoint[RANK] = loHit[LO] & hiHit[HI];
    end
  end

  // Group-pair enable: a nibble output survives only if the other
  // nibble shows an output in the complementary weight group.
  for (genvar p = 0; p < HALF_N; p++) begin : g_mask
    localparam int PW = popCount(p, HALF_W);
    localparam logic [HALF_N-1:0] PARTNER = weightMask(WEIGHT - PW);
    assign loPass[p] = loHit[p] & (|(hiHit & PARTNER));
    assign hiPass[p] = hiHit[p] & (|(loHit & PARTNER));
  end

  // Re-encode survivors into the inverted field, 8 inputs per bit.
  for (genvar b = 0; b < HALF_W; b++) begin : g_reenc
    localparam logic [HALF_N-1:0] ZMASK = bitClearMask(b);
    assign compWord[b]        = |(loPass & ZMASK);
    assign compWord[HALF_W+b] = |(hiPass & ZMASK);
  end

  cfdec_checker chk_i (
    .codeIn (compWord),
    .rails  (rails)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag <= 1'b0;
    end else if (strobes.clearFlag) begin
      errFlag <= 1'b0;
    end else begin
      errFlag <= strobes.checkEn & ~(rails[0] ^ rails[1]);
    end
  end

  // R4: a legal field lights exactly one strobe
  a_r4_single_point: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(fieldIn) == WEIGHT) |-> ($countones(ctrlPoint) == 1));

  // R4: an under-weight field lights nothing
  a_r4_no_light_point: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(fieldIn) < WEIGHT) |-> (ctrlPoint == '0));

  // R6: the group-pair enable leaves one survivor per nibble
  a_r6_one_survivor: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(fieldIn) == WEIGHT) |->
      ($countones(loPass) == 1 && $countones(hiPass) == 1));

  // R6: the re-encoded word is the inverse of a legal field
  a_r6_complement: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(fieldIn) == WEIGHT) |-> (compWord == ~fieldIn));

  // R5: a qualified illegal field raises the flag one edge later
  a_r5_flag_raised: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.checkEn && $countones(fieldIn) != WEIGHT) |=> errFlag);

  // R6: a qualified legal field never raises the flag
  a_r6_legal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.checkEn && $countones(fieldIn) == WEIGHT) |=> !errFlag);

  // R7: an idle cycle clears the flag
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.checkEn |=> !errFlag);

endmodule

// File: rtl/ctrl_field_decoder.sv
module ctrl_field_decoder
  import cfdec_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [FIELD_W-1:0]    fieldIn,
  input  logic                  fieldValid,
  output logic [NUM_POINTS-1:0] ctrlPoint,
  output logic [GROUP_N-1:0]    groupOut,
  output logic                  errFlag
);

  ctrlStrobe_t strobes;

  cfdec_ctrl ctrl_i (
    .fieldValid (fieldValid),
    .strobes    (strobes)
  );

  cfdec_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .fieldIn   (fieldIn),
    .strobes   (strobes),
    .ctrlPoint (ctrlPoint),
    .groupOut  (groupOut),
    .errFlag   (errFlag)
  );

  // R8: reset holds the flag low
  always_comb begin
    if (!rstN) begin
      a_r8_reset_low: assert (errFlag == 1'b0);
    end
  end

endmodule

// File: tb/ctrl_field_decoder_tb_top.sv
module ctrl_field_decoder_tb_top;

  localparam int CLK_NS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  fieldIn = 8'h00;
  logic        fieldValid = 1'b0;
  logic [69:0] ctrlPoint;
  logic [31:0] groupOut;
  logic        errFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_NS / 2) clk = ~clk;

  ctrl_field_decoder dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .fieldIn    (fieldIn),
    .fieldValid (fieldValid),
    .ctrlPoint  (ctrlPoint),
    .groupOut   (groupOut),
    .errFlag    (errFlag)
  );

  function automatic int ones8(input logic [7:0] v);
    int n;
    n = 0;
    for (int b = 0; b < 8; b++) n += int'(v[b]);
    return n;
  endfunction

  // R1: strobe k fires when the field covers the k-th weight-four value
  function automatic logic [69:0] expPoints(input logic [7:0] f);
    logic [69:0] e;
    int k;
    e = '0;
    k = 0;
    for (int v = 0; v < 256; v++) begin
      if (ones8(8'(v)) == 4) begin
        if ((f & 8'(v)) == 8'(v)) e[k] = 1'b1;
        k++;
      end
    end
    return e;
  endfunction

  // R2: nibble pattern coverage
  function automatic logic [31:0] expGroups(input logic [7:0] f);
    logic [31:0] e;
    for (int p = 0; p < 16; p++) begin
      e[p]    = ((f[3:0] & 4'(p)) == 4'(p));
      e[16+p] = ((f[7:4] & 4'(p)) == 4'(p));
    end
    return e;
  endfunction

  function automatic logic expErr(input logic [7:0] f, input logic v);
    return v && (ones8(f) != 4);
  endfunction

  task automatic applyVec(input logic [7:0] f, input logic v, input string tag);
    logic e;
    @(negedge clk);
    fieldIn    = f;
    fieldValid = v;
    #1;
    nChecks++;
    if (ctrlPoint !== expPoints(f)) begin
      nFails++;
      $display("FAIL %s R1 ctrlPoint field=%h got %h exp %h", tag, f, ctrlPoint, expPoints(f));
    end
    nChecks++;
    if (groupOut !== expGroups(f)) begin
      nFails++;
      $display("FAIL %s R2 groupOut field=%h got %h exp %h", tag, f, groupOut, expGroups(f));
    end
    @(posedge clk);
    #1;
    e = expErr(f, v);
    nChecks++;
    if (errFlag !== e) begin
      nFails++;
      $display("FAIL %s errFlag field=%h valid=%b got %b exp %b", tag, f, v, errFlag, e);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired got running exp finished");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_0C0D);
    fieldIn    = 8'h03;
    fieldValid = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    nChecks++;
    if (errFlag !== 1'b0) begin
      nFails++;
      $display("FAIL R8 errFlag in reset got %b exp 0", errFlag);
    end
    @(negedge clk);
    rstN = 1'b1;

    // Directed corner cases
    applyVec(8'hFF, 1'b1, "R3 all ones");
    applyVec(8'h0F, 1'b1, "R3 low full high empty");
    applyVec(8'hF0, 1'b1, "R3 high full low empty");
    applyVec(8'h00, 1'b1, "R5 zero qualified");
    applyVec(8'h00, 1'b0, "R7 zero idle");
    applyVec(8'h7F, 1'b1, "R5 weight seven");
    applyVec(8'h7F, 1'b0, "R7 illegal idle");
    applyVec(8'h07, 1'b1, "R4 weight three");
    applyVec(8'h3C, 1'b1, "R6 legal after illegal");

    // Exhaustive sweep, qualified
    for (int v = 0; v < 256; v++) begin
      if (ones8(8'(v)) == 4) applyVec(8'(v), 1'b1, "R4 R6 legal sweep");
      else                   applyVec(8'(v), 1'b1, "R5 illegal sweep");
    end
    // Exhaustive sweep, idle
    for (int v = 0; v < 256; v++) begin
      applyVec(8'(v), 1'b0, "R7 idle sweep");
    end

    // Constrained random: mostly legal codes, qualifier toggling
    for (int i = 0; i < 600; i++) begin
      logic [7:0] f;
      logic       vq;
      if (($urandom % 2) == 0) begin
        f = 8'h00;
        while (ones8(f) < 4) f[$urandom % 8] = 1'b1;
      end else begin
        f = 8'($urandom);
      end
      vq = (($urandom % 4) != 0);
      applyVec(f, vq, "R1 R5 R7 random");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule